// File: doc/BRIEF.md
# Cascaded Two-Stage Pacer Divider

This block produces the periodic trigger rate for a data converter. Two 16-bit down counters run in square-wave mode, one after the other, all inside the single system clock domain. Stage 0 counts every clock. Stage 1 counts once each time the stage 0 output rises. Each rising edge of the stage 1 output gives one single-cycle tick. The tick period is therefore C1*C2 system clocks, where C1 and C2 are the counts loaded into stage 0 and stage 1. The useful range of each count is 2 to 65535.

Software programs the block through an 8-bit register port. A control word picks a stage and an access type. The count is then written as one byte or as a low/high pair. A latch command freezes a copy of a stage's count so that it can be read back while the stage keeps running. Each stage output is produced as a registered level, not as a derived clock.

Top module: `pacer_divider`

## Requirements
- R1: After reset both stage outputs are high, tick_o is low and both stages are idle. An idle stage keeps its output high.
- R2: Address 3 takes a control word, and addresses 0 and 1 are the data ports of stage 0 and stage 1.
  - Bits [7:6] select the stage. Values 2 and 3 are ignored and leave both stages untouched.
  - Bits [5:4] set the access type: 00 latch, 01 low byte only, 10 high byte only, 11 low then high.
  - Bits [3:0] are ignored, so every stage runs in square-wave mode whatever those bits hold.
  - A control word with a non-latch access type puts the selected stage idle with its output high.
- R3: For an even count N, the output is high for N/2 counting clocks and low for N/2 counting clocks.
- R4: For an odd count N, the output is high for (N+1)/2 counting clocks and low for (N-1)/2 counting clocks.
- R5: With access type 11, writing the low byte halts the stage, which goes idle with its output high. Writing the high byte starts the stage with the new count, beginning with a high half-cycle.
- R6: With access type 01 the count becomes the written byte, with the high byte zero. With access type 10 the count becomes the written byte times 256. In both types a single write to an idle stage starts it.
- R7: A single-byte count written while the stage runs leaves the current half-cycle unchanged. The new count applies from the next reload.
- R8: Access type 00 copies the stage's current count into a hold register. Reads then return the held value (low byte then high byte under access type 11) while counting goes on. A latch command issued while a value is still held is ignored. The hold is released once it has been read in full.
- R9: Stage 1 counts once per rising edge of the stage 0 output, so the tick period is C1*C2 clocks.
- R10: tick_o is a one-cycle pulse. It goes high in the first cycle in which the stage 1 output is high again.
- R11: A read of a data port with no value held returns the live count, in the byte order that the access type gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (divider input rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (advances the byte order) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| stage_out_o | output | 2 | Square-wave output of each stage |
| tick_o | output | 1 | Pacer tick, one cycle per final period |

## Verification
- A write is taken at the clock edge that samples wr_i. The stop or start it causes is registered, so the stage acts one edge later.
- After that, a stage output changes at the edge that ends each half-cycle. tick_o follows at the same edge at which stage 1 goes high.
- The bench drives inputs and samples outputs on the falling clock edge. It measures each phase length as the number of falling-edge samples at a steady level, and each tick period as the number of samples between two ticks, so results do not depend on the absolute start latency.
- Read data is combinational and is sampled one time unit after the address is driven, before the edge that advances the byte order.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_PAIR  = 2'b11
  } acc_e;
endpackage

// File: rtl/pacer_port.sv
module pacer_port
  import pacer_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  acc_e             ctl_acc_i,
  input  logic             dat_we_i,
  input  logic             dat_re_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] live_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             stop_o,
  output logic             start_o
);
  acc_e             acc_q;
  logic             wr_hi_q, rd_hi_q, latched_q, stop_q, start_q;
  logic [CNT_W-1:0] hold_q, count_q;
  logic [CNT_W-1:0] src;
  logic             hi_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= ACC_PAIR;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
      stop_q    <= 1'b0;
      start_q   <= 1'b0;
      hold_q    <= '0;
      count_q   <= '0;
    end else begin
      stop_q  <= 1'b0;
      start_q <= 1'b0;
      if (ctl_we_i) begin
        if (ctl_acc_i == ACC_LATCH) begin
          if (!latched_q) begin
            hold_q    <= live_i;
            latched_q <= 1'b1;
            rd_hi_q   <= 1'b0;
          end
        end else begin
          acc_q     <= ctl_acc_i;
          wr_hi_q   <= 1'b0;
          rd_hi_q   <= 1'b0;
          latched_q <= 1'b0;
          stop_q    <= 1'b1;
        end
      end else begin
        if (dat_we_i) begin
          case (acc_q)
            ACC_LO: begin
              count_q <= {{BUS_W{1'b0}}, wdata_i};
              start_q <= 1'b1;
            end
            ACC_HI: begin
              count_q <= {wdata_i, {BUS_W{1'b0}}};
              start_q <= 1'b1;
            end
            ACC_PAIR: begin
              if (!wr_hi_q) begin
                count_q[BUS_W-1:0] <= wdata_i;
                wr_hi_q            <= 1'b1;
                stop_q             <= 1'b1;   // first byte halts the stage
              end else begin
                count_q[CNT_W-1:BUS_W] <= wdata_i;
                wr_hi_q                <= 1'b0;
                start_q                <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (dat_re_i) begin
          if (acc_q == ACC_PAIR) rd_hi_q <= ~rd_hi_q;
          if (latched_q && (acc_q != ACC_PAIR || rd_hi_q)) latched_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    src     = latched_q ? hold_q : live_i;
    hi_sel  = (acc_q == ACC_HI) || (acc_q == ACC_PAIR && rd_hi_q);
    rdata_o = hi_sel ? src[CNT_W-1:BUS_W] : src[BUS_W-1:0];
  end

  assign count_o = count_q;
  assign stop_o  = stop_q;
  assign start_o = start_q;

  // Held value must not move until released by a read or a new access type.
  assert_hold_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_q && !dat_re_i && !ctl_we_i) |=> (latched_q && $stable(hold_q)));
endmodule

// File: rtl/pacer_sqwave.sv
module pacer_sqwave #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             stop_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             out_o,
  output logic             rise_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, dec, nxt;
  logic             out_q, run_q, fresh_q, step, term;

  always_comb begin
    // odd count: first step of high phase takes 1, of low phase takes 3
    if (fresh_q && cnt_q[0]) dec = out_q ? CNT_W'(1) : CNT_W'(3);
    else                     dec = CNT_W'(2);
    nxt    = cnt_q - dec;
    term   = (nxt == '0);
    step   = run_q && en_i && !stop_i;
    rise_o = step && term && !out_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      out_q   <= 1'b1;
      run_q   <= 1'b0;
      fresh_q <= 1'b0;
    end else if (stop_i) begin
      run_q <= 1'b0;
      out_q <= 1'b1;
    end else if (start_i && !run_q) begin
      run_q   <= 1'b1;
      out_q   <= 1'b1;
      cnt_q   <= count_i;
      fresh_q <= 1'b1;
    end else if (step) begin
      if (term) begin
        out_q   <= ~out_q;
        cnt_q   <= count_i;   // reload picks up any rewritten count
        fresh_q <= 1'b1;
      end else begin
        cnt_q   <= nxt;
        fresh_q <= 1'b0;
      end
    end
  end

  assign out_o = out_q;
  assign cnt_o = cnt_q;

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> out_q);
  assert_stop_idles_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (out_q && !run_q));
  assert_half_steady_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && !stop_i && !term) |=> $stable(out_q));
  assert_count_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !stop_i && !(start_i && !run_q)) |=> $stable(cnt_q));
endmodule

// File: rtl/pacer_divider.sv
module pacer_divider
  import pacer_pkg::*;
#(
  parameter int N_STAGES = 2,
  parameter int BUS_W    = 8,
  parameter int ADDR_W   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  output logic [N_STAGES-1:0] stage_out_o,
  output logic                tick_o
);
  localparam int CNT_W    = 2 * BUS_W;
  localparam int LAST     = N_STAGES - 1;
  localparam logic [ADDR_W-1:0] CTL_ADDR = {ADDR_W{1'b1}};

  logic [N_STAGES-1:0] en, rise;
  logic [BUS_W-1:0]    rd_arr [N_STAGES];
  logic                ctl_hit, tick_q;
  logic [1:0]          ctl_sel;
  acc_e                ctl_acc;

  assign ctl_hit = wr_i && (addr_i == CTL_ADDR);
  assign ctl_sel = wdata_i[BUS_W-1:BUS_W-2];
  assign ctl_acc = acc_e'(wdata_i[BUS_W-3:BUS_W-4]);
  assign en[0]   = 1'b1;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    logic [CNT_W-1:0] count, live;
    logic             stop, start, out;

    if (i > 0) begin : g_chain
      assign en[i] = rise[i-1];
    end

    pacer_port #(.BUS_W(BUS_W)) i_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctl_we_i (ctl_hit && (ctl_sel == 2'(i))),
      .ctl_acc_i(ctl_acc),
      .dat_we_i (wr_i && (addr_i == ADDR_W'(i))),
      .dat_re_i (rd_i && (addr_i == ADDR_W'(i))),
      .wdata_i  (wdata_i),
      .live_i   (live),
      .rdata_o  (rd_arr[i]),
      .count_o  (count),
      .stop_o   (stop),
      .start_o  (start)
    );

    pacer_sqwave #(.CNT_W(CNT_W)) i_wave (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[i]),
      .stop_i (stop),
      .start_i(start),
      .count_i(count),
      .out_o  (out),
      .rise_o (rise[i]),
      .cnt_o  (live)
    );

    assign stage_out_o[i] = out;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_STAGES; k++)
      if (addr_i == ADDR_W'(k)) rdata_o = rd_arr[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= rise[LAST];
  end
  assign tick_o = tick_q;

  assert_tick_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  assert_tick_on_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> stage_out_o[LAST]);
  assert_tick_after_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stage_out_o[LAST]) |-> tick_o);
endmodule

// File: tb/test_pacer_divider.sv
module test_pacer_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] sout;
  logic       tick;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pacer_divider i_pacer_divider (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .stage_out_o(sout), .tick_o(tick)
  );

  // count N, expected high, expected low
  localparam int VEC[9][3] = '{
    '{2, 1, 1}, '{3, 2, 1}, '{4, 2, 2}, '{5, 3, 2}, '{7, 4, 3},
    '{10, 5, 5}, '{11, 6, 5}, '{300, 150, 150}, '{257, 129, 128}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_fall(int idx);
    bit prev = sout[idx];
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (prev && !sout[idx]) return;
      prev = sout[idx];
    end
  endtask

  // measure the low phase starting now-ish, then the following high phase
  task automatic meas(int idx, output int lo, output int hi);
    wait_fall(idx);
    lo = 1; hi = 0;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (sout[idx]) break;
      lo++;
    end
    hi = 1;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (!sout[idx]) break;
      hi++;
    end
  endtask

  task automatic tick_period(output int p, output int width_ok, output int high_ok);
    p = 0;
    for (int g = 0; g < 5000; g++) begin @(negedge clk); if (tick) break; end
    high_ok = sout[1];
    @(negedge clk); width_ok = !tick; p = 1;
    for (int g = 0; g < 5000; g++) begin
      if (tick) break;
      @(negedge clk); p++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lo, hi, p, w, h, v, w2;
    logic [7:0] b0, b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 stage0 out", sout[0], 1);
    chk("R1 stage1 out", sout[1], 1);
    chk("R1 tick", tick, 0);

    // R3/R4 table walk on stage 0, pair access (ctl 0x36)
    foreach (VEC[i]) begin
      wr_reg(2'd3, 8'h36);
      wr_reg(2'd0, VEC[i][0][7:0]);
      wr_reg(2'd0, VEC[i][0][15:8]);
      meas(0, lo, hi);
      chk((VEC[i][0] % 2) ? "R4 high" : "R3 high", hi, VEC[i][1]);
      chk((VEC[i][0] % 2) ? "R4 low" : "R3 low", lo, VEC[i][2]);
    end

    // R2 mode/flag bits ignored: 0x31 still square wave
    wr_reg(2'd3, 8'h31);
    wr_reg(2'd0, 8'd6); wr_reg(2'd0, 8'd0);
    meas(0, lo, hi);
    chk("R2 mode bits ignored high", hi, 3);
    chk("R2 mode bits ignored low", lo, 3);

    // R5 low byte halts, high byte restarts
    wr_reg(2'd3, 8'h36);
    wr_reg(2'd0, 8'd4); wr_reg(2'd0, 8'd0);
    repeat (10) @(negedge clk);
    wr_reg(2'd0, 8'd6);
    repeat (2) @(negedge clk);
    w = 1;
    for (int g = 0; g < 20; g++) begin @(negedge clk); if (!sout[0]) w = 0; end
    chk("R5 halted output high", w, 1);
    wr_reg(2'd0, 8'd0);
    meas(0, lo, hi);
    chk("R5 restart high", hi, 3);
    chk("R5 restart low", lo, 3);

    // R2 select value 2 ignored: stage 0 keeps N=6
    wr_reg(2'd3, 8'hB6);
    meas(0, lo, hi);
    chk("R2 bad select ignored low", lo, 3);
    chk("R2 bad select ignored high", hi, 3);

    // R6 high-byte only: 1 -> 256
    wr_reg(2'd3, 8'h26);
    wr_reg(2'd0, 8'd1);
    meas(0, lo, hi);
    chk("R6 high only low", lo, 128);
    chk("R6 high only high", hi, 128);

    // R6/R7 low-byte only, N=8, rewrite to 4 during a low half
    wr_reg(2'd3, 8'h16);
    wr_reg(2'd0, 8'd8);
    wait_fall(0);
    lo = 1;
    wr = 1'b1; addr = 2'd0; wdata = 8'd4;
    @(negedge clk); wr = 1'b0;
    if (!sout[0]) lo++;
    for (int g = 0; g < 100; g++) begin
      if (sout[0]) break;
      @(negedge clk);
      if (!sout[0]) lo++;
    end
    chk("R6 R7 current low half kept", lo, 4);
    hi = 0;
    for (int g = 0; g < 100; g++) begin
      if (!sout[0]) break;
      hi++;
      @(negedge clk);
    end
    chk("R7 new count after reload", hi, 2);

    // R8/R11 latch on a frozen stage 1 (stage 0 idle)
    wr_reg(2'd3, 8'h36);
    wr_reg(2'd3, 8'h76);
    wr_reg(2'd1, 8'h34); wr_reg(2'd1, 8'h12);
    repeat (3) @(negedge clk);
    wr_reg(2'd3, 8'h46);
    rd_reg(2'd1, b0); rd_reg(2'd1, b1);
    chk("R8 latched low", b0, 8'h34);
    chk("R8 latched high", b1, 8'h12);
    rd_reg(2'd1, b0); rd_reg(2'd1, b1);
    chk("R11 live low", b0, 8'h34);
    chk("R11 live high", b1, 8'h12);

    // R8 counting continues, second latch ignored
    wr_reg(2'd0, 8'd2); wr_reg(2'd0, 8'd0);
    repeat (10) @(negedge clk);
    wr_reg(2'd3, 8'h46);
    repeat (40) @(negedge clk);
    wr_reg(2'd3, 8'h46);
    rd_reg(2'd1, b0); rd_reg(2'd1, b1);
    v = {b1, b0};
    wr_reg(2'd3, 8'h46);
    rd_reg(2'd1, b0); rd_reg(2'd1, b1);
    w2 = {b1, b0};
    chk("R8 counting went on", int'(v < 'h1234), 1);
    chk("R8 second latch ignored", int'(v > w2 && (v - w2) >= 30), 1);

    // R9/R10 cascade 4*3 then 5*3
    wr_reg(2'd3, 8'h76); wr_reg(2'd1, 8'd3); wr_reg(2'd1, 8'd0);
    wr_reg(2'd3, 8'h36); wr_reg(2'd0, 8'd4); wr_reg(2'd0, 8'd0);
    tick_period(p, w, h);
    tick_period(p, w, h);
    chk("R9 tick period 4x3", p, 12);
    chk("R10 tick one cycle", w, 1);
    chk("R10 tick with stage1 high", h, 1);
    wr_reg(2'd3, 8'h36); wr_reg(2'd0, 8'd5); wr_reg(2'd0, 8'd0);
    tick_period(p, w, h);
    tick_period(p, w, h);
    chk("R9 tick period 5x3", p, 15);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule